// File: doc/BRIEF.md
# Threshold Comparator with Alert Queue

This block watches a stream of 12-bit two's-complement conversion results and drives one alert pin. Each result is compared against a programmable low limit and a programmable high limit. The alert asserts only after a programmed number of back-to-back out-of-limit results. The pin has a selectable active level. The alert can be latched until software reads the result or acknowledges the alert, or it can follow the data.

The pin is modelled as a data value plus an output enable, so a floating pin can be represented. When the high limit's sign bit is 1 and the low limit's sign bit is 0, the comparator is set aside and the pin becomes a data-ready indicator. In single-shot operation it follows the converter's idle flag. In continuous operation it gives a short pulse for every result.

Top module: `thc_alert_top`

## Requirements
- R1: After reset, the occurrence counter and the alert state are cleared. With the comparator enabled and ready mode off, the pin is driven at its deasserted level (`alert_out = ~pol_high`).
- R2: `queue_sel` = 2'b11 disables the comparator. While it is disabled, `alert_oe` is 0 and the counter and alert state are held cleared. For any other code, `alert_oe` is 1.
- R3: Each limit is the signed 12-bit value in bits 15:4 of its 16-bit input, and bits 3:0 are ignored. All comparisons are signed.
- R4: Traditional mode (`win_mode` = 0): a result greater than the high limit counts as out of limit. In non-latching operation, only a result below the low limit clears the alert. A result between the limits leaves the alert as it is.
- R5: Window mode (`win_mode` = 1): a result above the high limit or below the low limit is out of limit. In non-latching operation, a result inside the limits, bounds included, clears the alert.
- R6: `queue_sel` codes 2'b00, 2'b01 and 2'b10 require 1, 2 and 4 successive out-of-limit results before the alert asserts. Any in-limit result resets the count to zero. In traditional mode, in-limit means less than or equal to the high limit.
- R7: `pol_high` = 0 makes the asserted pin level low, and `pol_high` = 1 makes it high.
- R8: With `latch_en` = 1, an asserted alert stays asserted until a `res_read` or `alert_ack` pulse. With `latch_en` = 0, both pulses have no effect.
- R9: If a clear pulse and a result that completes the queue arrive in the same cycle, the alert stays asserted.
- R10: Ready mode is selected by `thr_hi[15]` = 1 and `thr_lo[15]` = 0. With `single_shot` = 1, the pin is asserted exactly while `conv_idle` = 1.
- R11: In ready mode with `single_shot` = 0, every `res_valid` asserts the pin for RDY_PULSE_CYC cycles, starting in the cycle after the strobe. A new strobe restarts the pulse.
- R12: A result sampled on a clock edge updates the pin in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | New conversion result strobe |
| res_data | input | 12 | Conversion result, two's complement |
| res_read | input | 1 | Result has been read (clears a latched alert) |
| alert_ack | input | 1 | Alert-response acknowledge (clears a latched alert) |
| thr_lo | input | 16 | Low limit register, value in bits 15:4 |
| thr_hi | input | 16 | High limit register, value in bits 15:4 |
| win_mode | input | 1 | 0 traditional, 1 window |
| pol_high | input | 1 | 0 asserted low, 1 asserted high |
| latch_en | input | 1 | 1 latching alert |
| queue_sel | input | 2 | Queue depth code, 2'b11 disables |
| single_shot | input | 1 | 1 single-shot, 0 continuous conversion |
| conv_idle | input | 1 | Converter idle / start status bit |
| alert_out | output | 1 | Pin data value |
| alert_oe | output | 1 | Pin output enable |

## Verification
The latched-alert clear, from `res_read` or `alert_ack`, can land in the same cycle as a result that completes the queue. The bench first latches an alert. It then drives a read pulse together with a further out-of-limit result, and expects the pin to stay asserted in the next cycle. A read pulse on its own in the following cycle must then release the pin, which shows that the clear still works and that the set simply takes priority.

// File: rtl/thc_pkg.sv
// Package: shared constants and queue-code decoding for the threshold comparator.
// Assumes the queue code is two bits wide, with the all-ones code meaning "off".
package thc_pkg;

    localparam int MAX_DEPTH = 4;
    localparam int CNT_W     = $clog2(MAX_DEPTH + 1);

    typedef enum logic [1:0] {
        Q_ONE  = 2'b00,
        Q_TWO  = 2'b01,
        Q_FOUR = 2'b10,
        Q_OFF  = 2'b11
    } queue_code_e;

    // Number of successive out-of-limit results a queue code asks for.
    function automatic logic [CNT_W-1:0] queue_depth(input logic [1:0] code);
        case (code)
            Q_ONE:   queue_depth = CNT_W'(1);
            Q_TWO:   queue_depth = CNT_W'(2);
            Q_FOUR:  queue_depth = CNT_W'(4);
            default: queue_depth = CNT_W'(MAX_DEPTH);
        endcase
    endfunction

endpackage

// File: rtl/thc_limit_eval.sv
// Module: purely combinational limit evaluation.
// Extracts the signed limits from the top bits of the limit registers and
// classifies one result. It reports whether the result is out of limit and
// whether it meets the clear condition of the selected mode.
// Assumes RES_W <= REG_W; the REG_W-RES_W low bits of each register carry no value.
module thc_limit_eval #(
    parameter int RES_W = 12,
    parameter int REG_W = 16
) (
    input  logic [RES_W-1:0] res,
    input  logic [REG_W-1:0] lo_reg,
    input  logic [REG_W-1:0] hi_reg,
    input  logic             window,
    output logic             out_of_limit,
    output logic             clear_cond
);
    localparam int PAD_W = REG_W - RES_W;

    logic signed [RES_W-1:0] res_s;
    logic signed [RES_W-1:0] lo_s;
    logic signed [RES_W-1:0] hi_s;
    logic                    above_hi;
    logic                    below_lo;
    logic                    unused_pad;

    assign res_s      = res;
    assign lo_s       = lo_reg[REG_W-1 -: RES_W];
    assign hi_s       = hi_reg[REG_W-1 -: RES_W];
    assign unused_pad = ^{lo_reg[PAD_W-1:0], hi_reg[PAD_W-1:0]};

    // Signed comparisons of the result against each limit.
    always_comb begin
        above_hi = res_s > hi_s;
        below_lo = res_s < lo_s;
    end

    // Mode-dependent classification: window treats both sides, traditional only the top.
    always_comb begin
        if (window) begin
            out_of_limit = above_hi | below_lo;
            clear_cond   = ~(above_hi | below_lo);
        end else begin
            out_of_limit = above_hi;
            clear_cond   = below_lo;
        end
    end
endmodule

// File: rtl/thc_alert_core.sv
// Module: successive-occurrence counter and alert state.
// Counts back-to-back out-of-limit results, saturating at MAX_DEPTH, and sets
// the alert when the count reaches the requested depth. Clears come from the
// mode's clear condition (non-latching) or from clear pulses (latching).
// A set in the same cycle as a clear pulse wins.
// Assumes the enable is low whenever the comparator must be idle.
module thc_alert_core
    import thc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             res_valid,
    input  logic             out_of_limit,
    input  logic             clear_cond,
    input  logic             latch,
    input  logic             clr_req,
    input  logic [CNT_W-1:0] depth,
    output logic             alert
);
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             alert_q, alert_nx;

    // Next-state logic: the count update, then clear, then set with priority.
    always_comb begin
        cnt_nx   = cnt_q;
        alert_nx = alert_q;
        if (latch && clr_req) begin
            alert_nx = 1'b0;
        end
        if (res_valid) begin
            if (out_of_limit) begin
                cnt_nx = (cnt_q == CNT_W'(MAX_DEPTH)) ? cnt_q : cnt_q + CNT_W'(1);
                if (cnt_nx >= depth) begin
                    alert_nx = 1'b1;
                end
            end else begin
                cnt_nx = '0;
                if (!latch && clear_cond) begin
                    alert_nx = 1'b0;
                end
            end
        end
        if (!enable) begin
            cnt_nx   = '0;
            alert_nx = 1'b0;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            alert_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_nx;
            alert_q <= alert_nx;
        end
    end

    assign alert = alert_q;

    assert_inlimit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && res_valid && !out_of_limit) |=> (cnt_q == '0));

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && latch && alert_q && !clr_req) |=> alert_q);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && res_valid && out_of_limit && (cnt_q >= depth - CNT_W'(1))) |=> alert_q);

    assert_rise_on_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_q) |-> $past(res_valid));

    assert_disabled_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!alert_q && cnt_q == '0));

    assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_DEPTH));
endmodule

// File: rtl/thc_ready_pulse.sv
// Module: fixed-length data-ready pulse generator.
// Each trigger loads a down-counter with PULSE_CYC. The output is active while
// the counter is non-zero, so the pulse starts in the cycle after the trigger
// and lasts PULSE_CYC cycles. A new trigger restarts it.
// Assumes PULSE_CYC >= 1.
module thc_ready_pulse #(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic active
);
    localparam int PW = $clog2(PULSE_CYC + 1);

    logic [PW-1:0] cnt_q;

    // Reload on a trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trigger) begin
            cnt_q <= PW'(PULSE_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - PW'(1);
        end
    end

    assign active = (cnt_q != '0);

    assert_pulse_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> active);

    assert_pulse_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PW'(PULSE_CYC));
endmodule

// File: rtl/thc_alert_top.sv
// Module: top of the threshold comparator with alert queue.
// Combines limit evaluation, the queued alert state and the ready pulse, and
// drives the pin value and its output enable. The ready mode is chosen from
// the limit sign bits.
// Assumes the control inputs are stable register outputs.
module thc_alert_top
    import thc_pkg::*;
#(
    parameter int RES_W         = 12,
    parameter int REG_W         = 16,
    parameter int RDY_PULSE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_read,
    input  logic             alert_ack,
    input  logic [REG_W-1:0] thr_lo,
    input  logic [REG_W-1:0] thr_hi,
    input  logic             win_mode,
    input  logic             pol_high,
    input  logic             latch_en,
    input  logic [1:0]       queue_sel,
    input  logic             single_shot,
    input  logic             conv_idle,
    output logic             alert_out,
    output logic             alert_oe
);
    logic             ready_mode;
    logic             cmp_on;
    logic             core_en;
    logic             out_of_limit;
    logic             clear_cond;
    logic             alert_st;
    logic             pulse_on;
    logic             asserted;
    logic [CNT_W-1:0] depth;

    // Mode decode: the ready indicator is picked by the limit sign bits.
    always_comb begin
        ready_mode = thr_hi[REG_W-1] & ~thr_lo[REG_W-1];
        cmp_on     = (queue_sel != Q_OFF);
        core_en    = cmp_on & ~ready_mode;
        depth      = queue_depth(queue_sel);
    end

    thc_limit_eval #(
        .RES_W (RES_W),
        .REG_W (REG_W)
    ) u_eval (
        .res          (res_data),
        .lo_reg       (thr_lo),
        .hi_reg       (thr_hi),
        .window       (win_mode),
        .out_of_limit (out_of_limit),
        .clear_cond   (clear_cond)
    );

    thc_alert_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (core_en),
        .res_valid    (res_valid),
        .out_of_limit (out_of_limit),
        .clear_cond   (clear_cond),
        .latch        (latch_en),
        .clr_req      (res_read | alert_ack),
        .depth        (depth),
        .alert        (alert_st)
    );

    thc_ready_pulse #(
        .PULSE_CYC (RDY_PULSE_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (res_valid & ready_mode & ~single_shot),
        .active  (pulse_on)
    );

    // Pin drive: choose the asserted source, then apply the polarity.
    always_comb begin
        if (ready_mode) begin
            asserted = single_shot ? conv_idle : pulse_on;
        end else begin
            asserted = alert_st;
        end
        alert_out = pol_high ? asserted : ~asserted;
        alert_oe  = cmp_on;
    end

    assert_alert_follows_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && !res_valid && !(latch_en && (res_read | alert_ack))) |=> $stable(alert_st));
endmodule

// File: tb/tb_thc_alert_top.sv
// Scoreboard bench: the driver pushes the expected pin state for each cycle,
// and the monitor pops it and compares it just after the clock edge.
module tb_thc_alert_top;

    localparam logic [15:0] T_HI = 16'h1000;   // +256
    localparam logic [15:0] T_LO = 16'h0800;   // +128

    typedef struct {
        bit    chk;
        bit    exp_out;
        bit    exp_oe;
        string tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic        res_read = 1'b0;
    logic        alert_ack = 1'b0;
    logic [15:0] thr_lo = T_LO;
    logic [15:0] thr_hi = T_HI;
    logic        win_mode = 1'b0;
    logic        pol_high = 1'b0;
    logic        latch_en = 1'b0;
    logic [1:0]  queue_sel = 2'b11;
    logic        single_shot = 1'b1;
    logic        conv_idle = 1'b0;
    logic        alert_out;
    logic        alert_oe;

    int       n_tests = 0;
    int       n_fail  = 0;
    bit       done    = 1'b0;
    sb_item_t sb[$];

    always #5 clk = ~clk;

    thc_alert_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid   (res_valid),
        .res_data    (res_data),
        .res_read    (res_read),
        .alert_ack   (alert_ack),
        .thr_lo      (thr_lo),
        .thr_hi      (thr_hi),
        .win_mode    (win_mode),
        .pol_high    (pol_high),
        .latch_en    (latch_en),
        .queue_sel   (queue_sel),
        .single_shot (single_shot),
        .conv_idle   (conv_idle),
        .alert_out   (alert_out),
        .alert_oe    (alert_oe)
    );

    // Driver: one cycle of stimulus plus the expected pin after the next edge.
    task automatic step(input bit v, input int d, input bit rd, input bit ak,
                        input bit exp_a, input bit exp_oe, input string tag);
        sb_item_t it;
        @(negedge clk);
        res_valid = v;
        res_data  = d[11:0];
        res_read  = rd;
        alert_ack = ak;
        it.chk     = 1'b1;
        it.exp_out = pol_high ? exp_a : ~exp_a;
        it.exp_oe  = exp_oe;
        it.tag     = tag;
        sb.push_back(it);
    endtask

    // Quiet cycle so that controls can change between steps.
    task automatic sync();
        @(negedge clk);
        res_valid = 1'b0;
        res_read  = 1'b0;
        alert_ack = 1'b0;
    endtask

    // Monitor: compare the pin just after each edge that has an item pending.
    initial begin
        sb_item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                n_tests++;
                if (alert_oe !== it.exp_oe ||
                    (it.exp_oe && alert_out !== it.exp_out)) begin
                    n_fail++;
                    $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b",
                             it.tag, alert_out, alert_oe, it.exp_out, it.exp_oe);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R2 disabled pin floats");
        sync(); queue_sel = 2'b00;
        step(0, 0, 0, 0, 0, 1, "R1 reset state deasserted");
        // R4/R12 traditional with hysteresis
        step(1, 300, 0, 0, 1, 1, "R4 above high asserts");
        step(1, 200, 0, 0, 1, 1, "R4 between limits holds");
        step(1, 128, 0, 0, 1, 1, "R4 equal low holds");
        step(1, 127, 0, 0, 0, 1, "R4 below low clears");
        // R3 limit slicing and signed compare
        sync(); thr_hi = 16'h100F;
        step(1, 256, 0, 0, 0, 1, "R3 equal high, low bits ignored");
        step(1, 257, 0, 0, 1, 1, "R3 just above high");
        sync(); thr_lo = 16'hFCE0;
        step(1, -40, 0, 0, 1, 1, "R3 negative inside holds");
        step(1, -60, 0, 0, 0, 1, "R3 negative below low clears");
        sync(); thr_lo = T_LO; thr_hi = T_HI;
        // R6 queue depths
        sync(); queue_sel = 2'b01;
        step(1, 300, 0, 0, 0, 1, "R6 depth2 first");
        step(1, 200, 0, 0, 0, 1, "R6 in-limit resets count");
        step(1, 300, 0, 0, 0, 1, "R6 depth2 restart");
        step(1, 300, 0, 0, 1, 1, "R6 depth2 second asserts");
        step(1, 100, 0, 0, 0, 1, "R6 clear");
        sync(); queue_sel = 2'b10;
        step(1, 300, 0, 0, 0, 1, "R6 depth4 one");
        step(1, 300, 0, 0, 0, 1, "R6 depth4 two");
        step(1, 300, 0, 0, 0, 1, "R6 depth4 three");
        step(1, 300, 0, 0, 1, 1, "R6 depth4 four asserts");
        step(1, 100, 0, 0, 0, 1, "R6 clear");
        // R7 polarity
        sync(); queue_sel = 2'b00;
        step(1, 300, 0, 0, 1, 1, "R7 asserted low");
        sync(); pol_high = 1'b1;
        step(0, 0, 0, 0, 1, 1, "R7 asserted high");
        step(1, 100, 0, 0, 0, 1, "R7 deasserted low");
        sync(); pol_high = 1'b0;
        // R5 window mode
        sync(); win_mode = 1'b1;
        step(1, 100, 0, 0, 1, 1, "R5 below low asserts");
        step(1, 200, 0, 0, 0, 1, "R5 inside clears");
        step(1, 300, 0, 0, 1, 1, "R5 above high asserts");
        step(1, 256, 0, 0, 0, 1, "R5 high bound inside");
        step(1, 128, 0, 0, 0, 1, "R5 low bound inside");
        step(1, 127, 0, 0, 1, 1, "R5 just below low");
        step(1, 200, 0, 0, 0, 1, "R5 clear");
        // R8 latching
        sync(); latch_en = 1'b1;
        step(1, 300, 0, 0, 1, 1, "R8 latch set");
        step(1, 200, 0, 0, 1, 1, "R8 in-limit keeps latch");
        step(0, 0, 1, 0, 0, 1, "R8 read clears");
        step(1, 300, 0, 0, 1, 1, "R8 latch set again");
        step(0, 0, 0, 1, 0, 1, "R8 ack clears");
        sync(); latch_en = 1'b0;
        step(1, 300, 0, 0, 1, 1, "R8 nonlatch set");
        step(0, 0, 1, 0, 1, 1, "R8 read ignored unlatched");
        step(0, 0, 0, 1, 1, 1, "R8 ack ignored unlatched");
        step(1, 200, 0, 0, 0, 1, "R8 clear");
        // R9 set and clear in the same cycle
        sync(); latch_en = 1'b1;
        step(1, 300, 0, 0, 1, 1, "R9 latch set");
        step(1, 300, 1, 0, 1, 1, "R9 set wins over read");
        step(0, 0, 1, 0, 0, 1, "R9 read alone clears");
        // R2 disable clears state
        step(1, 300, 0, 0, 1, 1, "R2 latched before disable");
        sync(); queue_sel = 2'b11;
        step(0, 0, 0, 0, 0, 0, "R2 disabled floats");
        sync(); queue_sel = 2'b00;
        step(0, 0, 0, 0, 0, 1, "R2 state cleared by disable");
        sync(); latch_en = 1'b0; win_mode = 1'b0;
        // R10 ready mode, single shot
        sync(); thr_hi = 16'h8000; thr_lo = 16'h0000; single_shot = 1'b1; conv_idle = 1'b1;
        step(0, 0, 0, 0, 1, 1, "R10 idle asserted");
        sync(); conv_idle = 1'b0;
        step(0, 0, 0, 0, 0, 1, "R10 busy deasserted");
        // R11 ready pulse, continuous
        sync(); single_shot = 1'b0;
        step(1, 0, 0, 0, 1, 1, "R11 pulse cycle1");
        step(0, 0, 0, 0, 1, 1, "R11 pulse cycle2");
        step(0, 0, 0, 0, 1, 1, "R11 pulse cycle3");
        step(0, 0, 0, 0, 1, 1, "R11 pulse cycle4");
        step(0, 0, 0, 0, 0, 1, "R11 pulse ends");
        step(1, 0, 0, 0, 1, 1, "R11 retrigger a");
        step(0, 0, 0, 0, 1, 1, "R11 retrigger b");
        step(1, 0, 0, 0, 1, 1, "R11 restart");
        step(0, 0, 0, 0, 1, 1, "R11 restart 2");
        step(0, 0, 0, 0, 1, 1, "R11 restart 3");
        step(0, 0, 0, 0, 1, 1, "R11 restart 4");
        step(0, 0, 0, 0, 0, 1, "R11 restart ends");
        sync();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule